// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, of `W` bits (8 by default). In each direction it can either pass data straight through or present a stored copy. Each direction has its own storage register and its own capture strobe. A register is loaded when its strobe goes from high to low. Each output path has a select that picks either the live word from the opposite bus or that direction's stored word. Data is never inverted.

An active-low output enable and a direction input decide which bus, if any, the block drives. Each bus is split into an input, an output word and a drive enable, so the pad ring can place its own tristate buffers. The capture strobes are treated as signals in the `clk` domain. A high-to-low change seen between two consecutive `clk` edges loads the bus word present at the second edge. The stored word appears on the output path after that edge.

Top module: `reg_bus_xcvr`

## Requirements
- R1: With `sel_ab` low (0 = live), `b_out` equals `a_in` bit for bit in the same cycle.
- R2: With `sel_ba` low (0 = live), `a_out` equals `b_in` bit for bit in the same cycle.
- R3: When `cap_ab` is sampled high at one `clk` edge and low at the next, the A-to-B register loads the `a_in` value present at that second edge.
- R4: When `cap_ba` is sampled high at one `clk` edge and low at the next, the B-to-A register loads the `b_in` value present at that second edge.
- R5: Loading either register does not depend on `oe_n` or `dir`; loads also happen while both buses are undriven.
- R6: A rising strobe, or a strobe held at either level, leaves its register unchanged.
- R7: With `oe_n` low, `dir` high asserts `b_oe` only, and `dir` low asserts `a_oe` only.
- R8: With `oe_n` high, both `a_oe` and `b_oe` are low.
- R9: `a_oe` and `b_oe` are never high together.
- R10: With `sel_ab` high (1 = stored), `b_out` shows the A-to-B register. With `sel_ba` high, `a_out` shows the B-to-A register.
- R11: A `clk` edge with `rst_n` low clears both registers to zero and forgets any strobe level seen before, so the first edge after reset never loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_ab | input | 1 | A-to-B capture strobe, loads on its falling transition |
| cap_ba | input | 1 | B-to-A capture strobe, loads on its falling transition |
| sel_ab | input | 1 | B output source: 0 live A, 1 stored A-to-B word |
| sel_ba | input | 1 | A output source: 0 live B, 1 stored B-to-A word |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| a_in | input | W | Word currently on bus A |
| a_out | output | W | Word the block presents to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Word currently on bus B |
| b_out | output | W | Word the block presents to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench targets the strobe edge rules. A design that loaded on the rising transition, or on a level, would overwrite a stored word when a strobe is raised or held. A design that kept its strobe history through reset would load on the first edge after reset. The bench also loads registers while the outputs are disabled and then re-enables them. A design that gated loading with the enable or the direction would show a stale stored word at that point. Long random runs with both strobes, both selects and every enable and direction combination would expose swapped selects, crossed registers, inverted bits, or a state in which both drive enables are high.

// File: rtl/xcvr_pkg.sv
// Package: shared types and constants for the registered bus transceiver.
// Assumes: index 0 is the A-to-B path and index 1 the B-to-A path.
package xcvr_pkg;

    localparam int NUM_PATHS = 2;
    localparam int PATH_AB   = 0;
    localparam int PATH_BA   = 1;

    // Output path source choice
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } path_src_e;

endpackage

// File: rtl/xcvr_capture.sv
// Module: one direction's storage register, loaded on a falling strobe.
// Assumes: strobe is already in the clk domain. The strobe history is cleared
// by reset, so a strobe held high through reset cannot cause a load.
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic strobe_q;
    logic fall;

    // Detect a high-to-low step between two consecutive clk edges
    always_comb begin
        fall = strobe_q & ~strobe;
    end

    // Remember the strobe level of the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
        end
    end

    // Load the bus word on a detected fall, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (fall) begin
            q <= din;
        end
    end

endmodule

// File: rtl/xcvr_path_mux.sv
// Module: output source selector for one direction, live or stored word.
// Assumes: purely combinational; no inversion on either leg.
module xcvr_path_mux #(
    parameter int W = 8
) (
    input  xcvr_pkg::path_src_e src,
    input  logic [W-1:0]        live,
    input  logic [W-1:0]        stored,
    output logic [W-1:0]        dout
);

    // Pick the source named by src
    always_comb begin
        unique case (src)
            xcvr_pkg::SRC_STORED: dout = stored;
            default:              dout = live;
        endcase
    end

endmodule

// File: rtl/xcvr_drive_ctl.sv
// Module: decodes enable and direction into per-bus drive enables.
// Assumes: the two enables must be mutually exclusive for the pads.
module xcvr_drive_ctl (
    input  logic oe_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);

    logic active;

    // Either bus may be driven only while the shared enable is low
    always_comb begin
        active = ~oe_n;
        b_oe   = active &  dir;
        a_oe   = active & ~dir;
    end

endmodule

// File: rtl/reg_bus_xcvr.sv
// Module: registered bidirectional transceiver between buses A and B.
// Each direction has a register loaded on its own falling strobe and a
// select between live and stored data. A shared active-low enable and a
// direction bit allow at most one bus to be driven.
// Assumes: strobes and bus inputs are synchronous to clk; pads sit outside.
module reg_bus_xcvr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_n,
    input  logic         dir,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    import xcvr_pkg::*;

    logic [NUM_PATHS-1:0]        strobe_v;
    logic [NUM_PATHS-1:0]        sel_v;
    logic [NUM_PATHS-1:0][W-1:0] src_word;
    logic [NUM_PATHS-1:0][W-1:0] stored_word;
    logic [NUM_PATHS-1:0][W-1:0] path_out;

    // Gather per-path controls and source words into indexed vectors
    always_comb begin
        strobe_v[PATH_AB] = cap_ab;
        strobe_v[PATH_BA] = cap_ba;
        sel_v[PATH_AB]    = sel_ab;
        sel_v[PATH_BA]    = sel_ba;
        src_word[PATH_AB] = a_in;
        src_word[PATH_BA] = b_in;
    end

    // One register and one selector per direction
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        xcvr_capture #(.W(W)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (strobe_v[p]),
            .din    (src_word[p]),
            .q      (stored_word[p])
        );

        xcvr_path_mux #(.W(W)) u_mux (
            .src    (path_src_e'(sel_v[p])),
            .live   (src_word[p]),
            .stored (stored_word[p]),
            .dout   (path_out[p])
        );
    end

    // Route each path to the bus opposite its source
    always_comb begin
        b_out = path_out[PATH_AB];
        a_out = path_out[PATH_BA];
    end

    xcvr_drive_ctl u_drive (
        .oe_n (oe_n),
        .dir  (dir),
        .a_oe (a_oe),
        .b_oe (b_oe)
    );

endmodule

// File: rtl/xcvr_checker.sv
// Module: property checker for reg_bus_xcvr, attached by bind below.
// Assumes: observes ports only; all properties are disabled while in reset.
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cap_ab,
    input logic         cap_ba,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         oe_n,
    input logic         dir,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe
);

    assert_live_ab_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ab |-> b_out == a_in);

    assert_live_ba_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ba |-> a_out == b_in);

    assert_load_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(cap_ab) |=> (!sel_ab || b_out == $past(a_in)));

    assert_load_ba_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(cap_ba) |=> (!sel_ba || a_out == $past(b_in)));

    assert_hold_ab_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cap_ab) && sel_ab |=> (!sel_ab || $stable(b_out)));

    assert_hold_ba_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cap_ba) && sel_ba |=> (!sel_ba || $stable(a_out)));

    assert_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (b_oe == dir) && (a_oe == !dir));

    assert_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !a_oe && !b_oe);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));

    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) && sel_ab && sel_ba |-> b_out == '0 && a_out == '0);

endmodule

bind reg_bus_xcvr xcvr_checker #(.W(W)) u_xcvr_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_ab (cap_ab),
    .cap_ba (cap_ba),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .oe_n   (oe_n),
    .dir    (dir),
    .a_in   (a_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_in   (b_in),
    .b_out  (b_out),
    .b_oe   (b_oe)
);

// File: tb/tb_reg_bus_xcvr.sv
// Bench: directed scenarios plus a random run. A behavioural reference
// model is compared with every output at each falling clock edge.
module tb_reg_bus_xcvr;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_ab = 1'b0, cap_ba = 1'b0;
    logic         sel_ab = 1'b0, sel_ba = 1'b0;
    logic         oe_n = 1'b1, dir = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    bit  model_on = 0;

    // reference state
    int  m_ab = 0, m_ba = 0;
    bit  p_ab = 0, p_ba = 0;

    always #5 clk = ~clk;

    reg_bus_xcvr #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_n(oe_n), .dir(dir),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: strobe history and stored words, updated per edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ab = 0; m_ba = 0; p_ab = 0; p_ba = 0;
        end else begin
            if (p_ab && !cap_ab) m_ab = int'(a_in);
            if (p_ba && !cap_ba) m_ba = int'(b_in);
            p_ab = cap_ab;
            p_ba = cap_ba;
        end
    end

    // Compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            chk(sel_ab ? "R10 b_out stored" : "R1 b_out live", int'(b_out),
                sel_ab ? m_ab : int'(a_in));
            chk(sel_ba ? "R10 a_out stored" : "R2 a_out live", int'(a_out),
                sel_ba ? m_ba : int'(b_in));
            chk(oe_n ? "R8 b_oe" : "R7 b_oe", int'(b_oe), int'(!oe_n && dir));
            chk(oe_n ? "R8 a_oe" : "R7 a_oe", int'(a_oe), int'(!oe_n && !dir));
            chk("R9 exclusive", int'(a_oe && b_oe), 0);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        // R11: reset with strobes held high, stored view selected
        cap_ab = 1; cap_ba = 1; sel_ab = 1; sel_ba = 1;
        a_in = 8'h77; b_in = 8'h88;
        repeat (3) step();
        rst_n = 1;
        cap_ab = 0; cap_ba = 0;   // first edge after reset must not load
        step();
        settle();
        chk("R11 b_out after reset", int'(b_out), 0);
        chk("R11 a_out after reset", int'(a_out), 0);
        model_on = 1;

        // R1, R7: live A to B, B driven
        step(); sel_ab = 0; sel_ba = 0; oe_n = 0; dir = 1; a_in = 8'h5A; b_in = 8'hC3;
        settle();
        chk("R1 live A->B", int'(b_out), 8'h5A);
        chk("R7 b_oe dir high", int'(b_oe), 1);
        chk("R7 a_oe dir high", int'(a_oe), 0);
        // R2, R7: live B to A, A driven
        step(); dir = 0;
        settle();
        chk("R2 live B->A", int'(a_out), 8'hC3);
        chk("R7 a_oe dir low", int'(a_oe), 1);
        // R8: both off
        step(); oe_n = 1;
        settle();
        chk("R8 a_oe off", int'(a_oe), 0);
        chk("R8 b_oe off", int'(b_oe), 0);

        // R3, R4, R5: load both registers while undriven
        step(); cap_ab = 1; cap_ba = 1; a_in = 8'hA5; b_in = 8'h3C;
        step(); cap_ab = 0; cap_ba = 0;
        step(); a_in = 8'h11; b_in = 8'h22; sel_ab = 1; sel_ba = 1;
        oe_n = 0; dir = 1;
        settle();
        chk("R3 stored A->B", int'(b_out), 8'hA5);
        chk("R4 stored B->A", int'(a_out), 8'h3C);
        chk("R5 load while disabled", int'(b_oe), 1);

        // R6: rising strobe and held levels do not load
        step(); cap_ab = 1; cap_ba = 1; a_in = 8'hFF; b_in = 8'hEE;
        step(); step();
        settle();
        chk("R6 rise no load A->B", int'(b_out), 8'hA5);
        chk("R6 rise no load B->A", int'(a_out), 8'h3C);
        step(); cap_ab = 0; a_in = 8'h0F;
        step(); a_in = 8'h99;
        step(); step();
        settle();
        chk("R6 low hold A->B", int'(b_out), 8'h0F);
        chk("R10 stored select", int'(b_out), 8'h0F);
        step(); sel_ab = 0;
        settle();
        chk("R1 live after store", int'(b_out), 8'h99);

        // Random run; per-cycle comparator checks every output
        for (int i = 0; i < 400; i++) begin
            step();
            a_in = W'($urandom); b_in = W'($urandom);
            cap_ab = 1'($urandom); cap_ba = 1'($urandom);
            sel_ab = 1'($urandom); sel_ba = 1'($urandom);
            oe_n = 1'($urandom); dir = 1'($urandom);
        end
        settle();
        model_on = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule